// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits between a command source and an embedded NOR flash array and owns every control strobe of that array. A command names one of four operations (read, word program, page erase, mass erase), a target block (main or information), a word address and, for a program, the data word. The sequencer then steps the array through the strobe states that operation needs. Each state lasts for an interval counted in clock cycles, and each interval comes from its own timing input.

While a sequence runs, `busy` stays high. A one-cycle `done` marks the first idle cycle afterwards. The block refuses three kinds of command, each with its own one-cycle error pulse. The first kind arrives while a sequence is still running. The second programs a word that has already been programmed since its last erase. The third would push the accumulated high-voltage program time of a row past a limit. The sequencer keeps its own record of programmed words and of per-row program time, and erases clear those records.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset and whenever no sequence runs, `busy`, `done`, all error pulses and every strobe (xe, ye, se, oe, prog, erase, mas1, nvstr, ifren) are low.
- R2: Operation code 0 (read) holds xe, ye, se and oe high, and prog, erase, mas1 and nvstr low, for READ_CYC cycles. `rdata` then holds the value that `fl_rdata` had in the last of those cycles.
- R3: Operation code 1 (word program) runs these states in order. First xe+prog for `t_nvs` cycles. Then xe+prog+nvstr for `t_pgs` cycles. Then xe+ye+prog+nvstr for `t_prog` cycles, with `fl_wdata` equal to the command data. Then xe+nvstr for `t_nvh` cycles. Finally all strobes low, still busy, for `t_rcv` cycles.
- R4: Operation code 2 (page erase) runs xe+erase for `t_nvs` cycles, then xe+erase+nvstr for `t_erase` cycles, then xe+nvstr for `t_nvh` cycles, then `t_rcv` recovery cycles. It clears the record of the page (row of 2^COL_W words, row = address bits above COL_W) in the selected block.
- R5: Operation code 3 (mass erase) follows the page-erase order, with mas1 high through the first three states. Its erase pulse uses `t_me` and its nvstr hold uses `t_nvh_me`.
- R6: A timing input of zero gives an interval of one cycle.
- R7: `fl_ifren` equals the command's `cmd_info` throughout the sequence, and `fl_addr` holds the command address. A mass erase with `cmd_info`=0 clears only the main-block record. With `cmd_info`=1 it clears both blocks.
- R8: A command presented while `busy` is high is ignored and raises `err_busy` in the next cycle.
- R9: A program to a word (block and address) programmed since its last erase produces no strobes and raises `err_reprog` in the next cycle.
- R10: A program is refused with `err_hv` when the row's accumulated program-pulse cycles plus this pulse would exceed `t_hv_max`. It produces no strobes. Erases reset the accumulation.
- R11: `done` is high for exactly the first cycle after the last state of an accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 program, 2 page erase, 3 mass erase |
| cmd_info | input | 1 | Target the information block |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Program data |
| t_nvs | input | CNT_W | Cycles from prog/erase rise to nvstr rise |
| t_pgs | input | CNT_W | Cycles from nvstr rise to ye rise |
| t_prog | input | CNT_W | Program pulse cycles (ye high) |
| t_nvh | input | CNT_W | nvstr hold after program or page erase |
| t_nvh_me | input | CNT_W | nvstr hold after mass erase |
| t_erase | input | CNT_W | Page erase pulse cycles |
| t_me | input | CNT_W | Mass erase pulse cycles |
| t_rcv | input | CNT_W | Recovery cycles |
| t_hv_max | input | CNT_W | Per-row program time limit in cycles |
| fl_rdata | input | DATA_W | Array read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence just finished |
| err_busy | output | 1 | Command refused: busy |
| err_reprog | output | 1 | Command refused: word already programmed |
| err_hv | output | 1 | Command refused: row time limit |
| rdata | output | DATA_W | Last read data |
| fl_xe | output | 1 | Row enable |
| fl_ye | output | 1 | Column enable |
| fl_se | output | 1 | Sense amplifier enable |
| fl_oe | output | 1 | Output enable |
| fl_prog | output | 1 | Program strobe |
| fl_erase | output | 1 | Erase strobe |
| fl_mas1 | output | 1 | Whole-block erase strobe |
| fl_nvstr | output | 1 | Non-volatile store strobe |
| fl_ifren | output | 1 | Information block select |
| fl_addr | output | ADDR_W | Array address |
| fl_wdata | output | DATA_W | Array write data |

## Verification
The hardest situation to reach is the refusal for row program time, because it only appears after several accepted programs to distinct words of one row. The stimulus lowers the row limit, programs consecutive words in a single row until the sum would pass the limit, and then erases the page to show that the accumulation restarts. A second hard case is a mass erase that leaves the information block untouched. It is reached by programming an information-block word, mass erasing the main block only, and then showing that a repeat program of that word is still refused.

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int COL_W    = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int READ_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_info,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CNT_W-1:0]  t_nvs,
  input  logic [CNT_W-1:0]  t_pgs,
  input  logic [CNT_W-1:0]  t_prog,
  input  logic [CNT_W-1:0]  t_nvh,
  input  logic [CNT_W-1:0]  t_nvh_me,
  input  logic [CNT_W-1:0]  t_erase,
  input  logic [CNT_W-1:0]  t_me,
  input  logic [CNT_W-1:0]  t_rcv,
  input  logic [CNT_W-1:0]  t_hv_max,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              busy,
  output logic              done,
  output logic              err_busy,
  output logic              err_reprog,
  output logic              err_hv,
  output logic [DATA_W-1:0] rdata,
  output logic              fl_xe,
  output logic              fl_ye,
  output logic              fl_se,
  output logic              fl_oe,
  output logic              fl_prog,
  output logic              fl_erase,
  output logic              fl_mas1,
  output logic              fl_nvstr,
  output logic              fl_ifren,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata
);

  localparam int WORDS  = 1 << ADDR_W;
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int NBITS  = 2 * WORDS;
  localparam int NROWS  = 2 * ROWS;
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYC - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD, ST_P_SET, ST_P_NVS, ST_P_PULSE, ST_P_HOLD,
    ST_E_SET, ST_E_PULSE, ST_E_HOLD, ST_RCV
  } phase_t;

  function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CNT_W:0] len_of(input logic [CNT_W-1:0] v);
    return (v == '0) ? (CNT_W+1)'(1) : {1'b0, v};
  endfunction

  phase_t              phase, nxt_phase;
  logic [CNT_W-1:0]    cnt, nxt_cnt;
  logic                mass_q, info_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [NBITS-1:0]    progd;
  logic [CNT_W:0]      hv_acc [NROWS];

  logic                idle, try_cmd, is_prog, was_prog, hv_bad, accept;
  logic [ROW_W-1:0]    row;
  logic [ROW_W:0]      ridx;
  logic [CNT_W:0]      hv_sum;

  assign idle     = (phase == ST_IDLE);
  assign busy     = !idle;
  assign try_cmd  = cmd_valid && idle;
  assign is_prog  = (cmd_op == 2'd1);
  assign row      = cmd_addr[ADDR_W-1:COL_W];
  assign ridx     = {cmd_info, row};
  assign was_prog = progd[{cmd_info, cmd_addr}];
  assign hv_sum   = hv_acc[ridx] + len_of(t_prog);
  assign hv_bad   = hv_sum > {1'b0, t_hv_max};
  assign accept   = try_cmd && !(is_prog && (was_prog || hv_bad));

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt;
    if (idle) begin
      if (accept) begin
        case (cmd_op)
          2'd0:    begin nxt_phase = ST_RD;    nxt_cnt = RD_LAST; end
          2'd1:    begin nxt_phase = ST_P_SET; nxt_cnt = last_of(t_nvs); end
          default: begin nxt_phase = ST_E_SET; nxt_cnt = last_of(t_nvs); end
        endcase
      end
    end else if (cnt != '0) begin
      nxt_cnt = cnt - 1'b1;
    end else begin
      case (phase)
        ST_P_SET:   begin nxt_phase = ST_P_NVS;   nxt_cnt = last_of(t_pgs); end
        ST_P_NVS:   begin nxt_phase = ST_P_PULSE; nxt_cnt = last_of(t_prog); end
        ST_P_PULSE: begin nxt_phase = ST_P_HOLD;  nxt_cnt = last_of(t_nvh); end
        ST_P_HOLD:  begin nxt_phase = ST_RCV;     nxt_cnt = last_of(t_rcv); end
        ST_E_SET:   begin nxt_phase = ST_E_PULSE; nxt_cnt = last_of(mass_q ? t_me : t_erase); end
        ST_E_PULSE: begin nxt_phase = ST_E_HOLD;  nxt_cnt = last_of(mass_q ? t_nvh_me : t_nvh); end
        ST_E_HOLD:  begin nxt_phase = ST_RCV;     nxt_cnt = last_of(t_rcv); end
        default:    begin nxt_phase = ST_IDLE;    nxt_cnt = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= ST_IDLE;
      cnt        <= '0;
      mass_q     <= 1'b0;
      info_q     <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      rdata      <= '0;
      done       <= 1'b0;
      err_busy   <= 1'b0;
      err_reprog <= 1'b0;
      err_hv     <= 1'b0;
    end else begin
      phase      <= nxt_phase;
      cnt        <= nxt_cnt;
      done       <= busy && (cnt == '0) && (nxt_phase == ST_IDLE);
      err_busy   <= cmd_valid && busy;
      err_reprog <= try_cmd && is_prog && was_prog;
      err_hv     <= try_cmd && is_prog && !was_prog && hv_bad;
      if (accept) begin
        mass_q <= (cmd_op == 2'd3);
        info_q <= cmd_info;
        addr_q <= cmd_addr;
        data_q <= cmd_wdata;
      end
      if (phase == ST_RD && cnt == '0) rdata <= fl_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progd <= '0;
      for (int r = 0; r < NROWS; r++) hv_acc[r] <= '0;
    end else if (accept) begin
      case (cmd_op)
        2'd1: begin
          progd[{cmd_info, cmd_addr}] <= 1'b1;
          hv_acc[ridx] <= hv_sum;
        end
        2'd2: begin
          for (int i = 0; i < NBITS; i++)
            if ((i / WORDS) == int'(cmd_info) && ((i % WORDS) >> COL_W) == int'(row))
              progd[i] <= 1'b0;
          hv_acc[ridx] <= '0;
        end
        2'd3: begin
          for (int i = 0; i < NBITS; i++)
            if (i < WORDS || cmd_info) progd[i] <= 1'b0;
          for (int r = 0; r < NROWS; r++)
            if (r < ROWS || cmd_info) hv_acc[r] <= '0;
        end
        default: ;
      endcase
    end
  end

  assign fl_xe    = busy && (phase != ST_RCV);
  assign fl_ye    = (phase == ST_RD) || (phase == ST_P_PULSE);
  assign fl_se    = (phase == ST_RD);
  assign fl_oe    = (phase == ST_RD);
  assign fl_prog  = (phase == ST_P_SET) || (phase == ST_P_NVS) || (phase == ST_P_PULSE);
  assign fl_erase = (phase == ST_E_SET) || (phase == ST_E_PULSE);
  assign fl_nvstr = (phase == ST_P_NVS) || (phase == ST_P_PULSE) || (phase == ST_P_HOLD) ||
                    (phase == ST_E_PULSE) || (phase == ST_E_HOLD);
  assign fl_mas1  = mass_q && ((phase == ST_E_SET) || (phase == ST_E_PULSE) || (phase == ST_E_HOLD));
  assign fl_ifren = busy && info_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;

  assert_prog_erase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_prog && fl_erase));
  assert_nvstr_after_hv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_nvstr) |-> $past(fl_prog || fl_erase));
  assert_nvstr_drops_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_nvstr) |-> (!fl_prog && !fl_erase));
  assert_pulse_under_nvstr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ye && fl_prog) |-> fl_nvstr);
  assert_mas1_in_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_mas1 |-> (fl_erase || fl_nvstr));
  assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> err_busy);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/flash_seq_ctrl_test.sv
module flash_seq_ctrl_test;
  localparam int AW = 6, DW = 16, CW = 16, RC = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_info = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_wdata = 0;
  logic [CW-1:0] t_nvs = 3, t_pgs = 4, t_prog = 6, t_nvh = 2, t_nvh_me = 5,
                 t_erase = 8, t_me = 12, t_rcv = 2, t_hv_max = 100;
  logic [DW-1:0] fl_rdata;
  logic busy, done, err_busy, err_reprog, err_hv;
  logic [DW-1:0] rdata, fl_wdata;
  logic fl_xe, fl_ye, fl_se, fl_oe, fl_prog, fl_erase, fl_mas1, fl_nvstr, fl_ifren;
  logic [AW-1:0] fl_addr;

  logic [DW-1:0] fmem [128];
  assign fl_rdata = fmem[{fl_ifren, fl_addr}];

  flash_seq_ctrl #(.ADDR_W(AW), .COL_W(4), .DATA_W(DW), .CNT_W(CW), .READ_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_info(cmd_info),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .t_nvs(t_nvs), .t_pgs(t_pgs), .t_prog(t_prog),
    .t_nvh(t_nvh), .t_nvh_me(t_nvh_me), .t_erase(t_erase), .t_me(t_me), .t_rcv(t_rcv),
    .t_hv_max(t_hv_max), .fl_rdata(fl_rdata), .busy(busy), .done(done), .err_busy(err_busy),
    .err_reprog(err_reprog), .err_hv(err_hv), .rdata(rdata), .fl_xe(fl_xe), .fl_ye(fl_ye),
    .fl_se(fl_se), .fl_oe(fl_oe), .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_mas1(fl_mas1),
    .fl_nvstr(fl_nvstr), .fl_ifren(fl_ifren), .fl_addr(fl_addr), .fl_wdata(fl_wdata));

  int checks = 0, failures = 0;
  logic [9:0] q [$];
  bit shown_busy = 0, progd [128], last_read = 0;
  int acc [8];
  logic [DW-1:0] exp_rdata, cur_data;
  logic [AW-1:0] cur_addr;
  string cur_req = "R1";
  bit exp_eb, exp_er, exp_eh;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int L(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic pushv(input int n, input logic [9:0] v);
    repeat (n) q.push_back(v);
  endtask

  // vector: busy xe ye se oe prog erase mas1 nvstr ifren
  task automatic model_accept(input logic [1:0] op, input bit info, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
    int idx, r;
    logic i0;
    idx = int'(info) * 64 + int'(a);
    r = int'(info) * 4 + int'(a) / 16;
    i0 = info;
    case (op)
      2'd0: begin
        cur_req = tag; cur_addr = a; last_read = 1; exp_rdata = fmem[idx];
        pushv(RC, {5'b11111, 4'b0000, i0});
      end
      2'd1: begin
        if (progd[idx]) exp_er = 1;
        else if (acc[r] + L(t_prog) > int'(t_hv_max)) exp_eh = 1;
        else begin
          cur_req = tag; cur_addr = a; cur_data = d; last_read = 0;
          progd[idx] = 1; acc[r] += L(t_prog); fmem[idx] = d;
          pushv(L(t_nvs),  {5'b11000, 4'b1000, i0});
          pushv(L(t_pgs),  {5'b11000, 4'b1001, i0});
          pushv(L(t_prog), {5'b11100, 4'b1001, i0});
          pushv(L(t_nvh),  {5'b11000, 4'b0001, i0});
          pushv(L(t_rcv),  {5'b10000, 4'b0000, i0});
        end
      end
      default: begin
        bit m;
        m = (op == 2'd3);
        cur_req = tag; cur_addr = a; last_read = 0;
        for (int k = 0; k < 128; k++)
          if (m ? (k < 64 || info) : (k / 64 == int'(info) && (k % 64) / 16 == int'(a) / 16)) begin
            progd[k] = 0; fmem[k] = '1;
          end
        for (int k = 0; k < 8; k++)
          if (m ? (k < 4 || info) : (k == r)) acc[k] = 0;
        pushv(L(t_nvs),                   {5'b11000, 2'b01, m, 1'b0, i0});
        pushv(L(m ? t_me : t_erase),      {5'b11000, 2'b01, m, 1'b1, i0});
        pushv(L(m ? t_nvh_me : t_nvh),    {5'b11000, 2'b00, m, 1'b1, i0});
        pushv(L(t_rcv),                   {5'b10000, 4'b0000, i0});
      end
    endcase
  endtask

  task automatic step(input string tag);
    logic [9:0] v, act;
    bit exp_done;
    exp_eb = 0; exp_er = 0; exp_eh = 0; exp_done = 0;
    if (cmd_valid) begin
      if (shown_busy) exp_eb = 1;
      else model_accept(cmd_op, cmd_info, cmd_addr, cmd_wdata, tag);
    end
    @(posedge clk); #2;
    if (q.size() > 0) v = q.pop_front();
    else begin v = '0; exp_done = shown_busy; end
    shown_busy = v[9];
    act = {busy, fl_xe, fl_ye, fl_se, fl_oe, fl_prog, fl_erase, fl_mas1, fl_nvstr, fl_ifren};
    check(act == v, v[9] ? cur_req : "R1", "strobes", act, v);
    check(done == exp_done, "R11", "done", done, exp_done);
    check(err_busy == exp_eb, "R8", "err_busy", err_busy, exp_eb);
    check(err_reprog == exp_er, "R9", "err_reprog", err_reprog, exp_er);
    check(err_hv == exp_eh, "R10", "err_hv", err_hv, exp_eh);
    if (v[9]) check(fl_addr == cur_addr, "R7", "fl_addr", fl_addr, cur_addr);
    if (v[7] && v[4]) check(fl_wdata == cur_data, "R3", "fl_wdata", fl_wdata, cur_data);
    if (exp_done && last_read) check(rdata == exp_rdata, "R2", "rdata", rdata, exp_rdata);
  endtask

  task automatic issue(input logic [1:0] op, input bit info, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    cmd_valid = 1; cmd_op = op; cmd_info = info; cmd_addr = a; cmd_wdata = d;
    step(tag);
    cmd_valid = 0;
  endtask

  task automatic finish_seq();
    while (q.size() > 0) step("R1");
    step("R11");
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int k = 0; k < 128; k++) begin fmem[k] = '1; progd[k] = 0; end
    for (int k = 0; k < 8; k++) acc[k] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step("R1"); step("R1");

    issue(0, 0, 3, 0, "R2"); finish_seq();              // read erased word
    issue(1, 0, 3, 16'h1234, "R3"); finish_seq();       // program
    issue(0, 0, 3, 0, "R2"); finish_seq();              // read back
    issue(1, 0, 3, 16'h5555, "R9"); step("R9"); step("R9"); // reprogram refused
    issue(1, 0, 5, 16'h00A5, "R3");
    step("R8"); step("R8");
    issue(1, 0, 6, 16'h0BAD, "R8");                     // refused while busy
    finish_seq();
    issue(1, 0, 6, 16'h0C0C, "R8"); finish_seq();       // ignored earlier, accepted now
    issue(2, 0, 1, 0, "R4"); finish_seq();              // page erase row 0
    issue(1, 0, 3, 16'h7777, "R4"); finish_seq();       // programmable again
    t_nvs = 0; t_pgs = 0; t_prog = 0; t_nvh = 0; t_rcv = 0;
    issue(1, 0, 20, 16'h4242, "R6"); finish_seq();      // minimum intervals
    issue(2, 0, 20, 0, "R6"); finish_seq();
    t_nvs = 3; t_pgs = 2; t_prog = 4; t_nvh = 2; t_rcv = 3; t_hv_max = 10;
    issue(1, 0, 32, 16'h1111, "R10"); finish_seq();
    issue(1, 0, 33, 16'h2222, "R10"); finish_seq();
    issue(1, 0, 34, 16'h3333, "R10"); step("R10"); step("R10"); // limit breach
    issue(2, 0, 40, 0, "R10"); finish_seq();            // same row erased
    issue(1, 0, 34, 16'h3333, "R10"); finish_seq();
    t_hv_max = 100;
    issue(1, 1, 3, 16'hABCD, "R7"); finish_seq();       // information block
    issue(0, 1, 3, 0, "R7"); finish_seq();
    issue(3, 0, 0, 0, "R5"); finish_seq();              // main only
    issue(1, 1, 3, 16'h0001, "R7"); step("R7"); step("R7"); // info still programmed
    issue(0, 0, 3, 0, "R5"); finish_seq();
    issue(3, 1, 0, 0, "R7"); finish_seq();              // both blocks
    issue(1, 1, 3, 16'h0F0F, "R7"); finish_seq();
    issue(0, 1, 3, 0, "R7"); finish_seq();
    step("R1"); step("R1");
    summary();
  end
endmodule